// File: doc/BRIEF.md
# Serial Interrupt Line Peripheral Agent

This block is the peripheral end of a shared, open-drain serial interrupt wire that runs on the bus clock. It takes a vector of active-high interrupt request inputs and reports them to a host, one per time slot, in frames that the host opens with a start pulse. The wire is never driven directly. The agent drives three registered signals: drive-low, drive-high and an output enable. It also reads back the sampled level of the wire.

In continuous mode the agent only follows start pulses from the host. In quiet mode it may also wake an idle wire. When an interrupt input has changed since it was last reported, the agent pulls the wire low for a single clock and the host then stretches that pulse into a full start pulse. The agent counts three-clock slots: a sample phase, a recovery phase and a turn-around phase. It then reads the length of the host's closing low pulse to decide the mode for the next round, and returns to idle.

Top module: `sirq_agent`

## Requirements
- R1: After a synchronous reset, drive_low, drive_high and drive_oe are 0 and quiet_mode is 0, which means continuous mode.
- R2: In idle, a run of START_MIN to START_MAX consecutive low samples of line_in, followed by a high sample, opens the data frames. The sample phase of slot 0 is the clock period that follows the edge at which line_in is first sampled high.
- R3: In idle, a low run that is shorter than START_MIN or longer than START_MAX opens no frames, and the agent stays released.
- R4: Each slot n lasts three clocks in the order sample, recovery, turn-around. In the sample phase of slot n, drive_low is 1 if bit n of the reported vector is 1 (active). Otherwise the agent leaves the wire released.
- R5: In the recovery phase drive_high is 1 only if the agent drove low in the sample phase just before it. drive_low and drive_high are never 1 together.
- R6: In the turn-around phase everything is released. drive_oe is 1 exactly when drive_low or drive_high is 1.
- R7: The reported vector is captured from irq_in at the edge that opens the frames. Changes on irq_in during the frames do not alter what the slots carry.
- R8: After the last slot, the next low run on the wire is the stop pulse and the agent does not drive during it. A stop pulse of STOP_QUIET_LEN samples sets quiet_mode to 1. A stop pulse of STOP_CONT_LEN samples clears quiet_mode. Any other length leaves quiet_mode as it was. The agent then returns to idle.
- R9: In quiet mode, in idle, with line_in sampled high and irq_in different from the last reported vector, the agent drives drive_low for exactly one clock and then releases the wire.
- R10: In continuous mode the agent never starts a start pulse, whatever irq_in does.
- R11: In quiet mode, in idle, with irq_in equal to the last reported vector, the agent leaves the wire released.
- R12: drive_low is never 1 in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SLOTS | Interrupt requests, active high; bit n is carried in slot n |
| line_in | input | 1 | Sampled level of the shared wire (1 = high) |
| drive_low | output | 1 | Pull the wire low this clock |
| drive_high | output | 1 | Drive the wire high this clock |
| drive_oe | output | 1 | Output enable of the wire driver |
| quiet_mode | output | 1 | 1 = quiet mode, 0 = continuous mode |

## Verification
The bench builds the agent with NUM_SLOTS set to 5 and the start window left at 4 to 8 clocks. Five slots keep each round short, so dozens of rounds fit in the run. That brings within reach the handoff from the last slot to the stop pulse, mode switches in both directions, and wake-ups that the agent starts itself at both edges of the start window. Start lengths just outside the window (3 and 9) and a stop length that belongs to neither mode (5) exercise the reject paths.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FRAMES = 2'd1,
    ST_STOP   = 2'd2
  } agent_state_e;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2
  } slot_phase_e;
endpackage

// File: rtl/sirq_lowrun.sv
// Measures consecutive low samples of the wire and flags the edge that ends a run.
module sirq_lowrun #(
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  output logic [RUN_W-1:0] run_len,
  output logic             rise
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
    end else if (line_in) begin
      run_len <= '0;
    end else if (run_len != {RUN_W{1'b1}}) begin
      run_len <= run_len + 1'b1;
    end
  end

  // high sample that closes a low run; run_len still holds its length
  assign rise = line_in && (run_len != '0);
endmodule

// File: rtl/sirq_slot_ctr.sv
// Tracks slot index and phase of the data frames; exposes next-state for registered outputs.
module sirq_slot_ctr
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 21,
  parameter int SLOT_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  output logic              active_q,
  output logic [SLOT_W-1:0] slot_q,
  output slot_phase_e       phase_q,
  output logic              nxt_active,
  output logic [SLOT_W-1:0] nxt_slot,
  output slot_phase_e       nxt_phase,
  output logic              last
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  assign last = active_q && (phase_q == PH_TURN) && (slot_q == LAST_SLOT);

  always_comb begin
    nxt_active = active_q;
    nxt_slot   = slot_q;
    nxt_phase  = phase_q;
    if (load) begin
      nxt_active = 1'b1;
      nxt_slot   = '0;
      nxt_phase  = PH_SAMPLE;
    end else if (active_q) begin
      case (phase_q)
        PH_SAMPLE:  nxt_phase = PH_RECOVER;
        PH_RECOVER: nxt_phase = PH_TURN;
        default: begin
          nxt_phase = PH_SAMPLE;
          if (slot_q == LAST_SLOT) nxt_active = 1'b0;
          else                     nxt_slot   = slot_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      phase_q  <= PH_SAMPLE;
    end else begin
      active_q <= nxt_active;
      slot_q   <= nxt_slot;
      phase_q  <= nxt_phase;
    end
  end
endmodule

// File: rtl/sirq_slot_drv.sv
// Registered wire drivers computed from the next slot/phase and the wake request.
module sirq_slot_drv
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 21,
  parameter int SLOT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 nxt_active,
  input  logic [SLOT_W-1:0]    nxt_slot,
  input  slot_phase_e          nxt_phase,
  input  logic [NUM_SLOTS-1:0] report_nxt,
  input  logic                 wake_req,
  output logic                 drive_low,
  output logic                 drive_high,
  output logic                 drive_oe
);
  logic low_d;
  logic high_d;

  always_comb begin
    low_d  = wake_req;
    high_d = 1'b0;
    if (nxt_active) begin
      if (nxt_phase == PH_SAMPLE)  low_d  = report_nxt[nxt_slot];
      if (nxt_phase == PH_RECOVER) high_d = drive_low;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_low  <= 1'b0;
      drive_high <= 1'b0;
      drive_oe   <= 1'b0;
    end else begin
      drive_low  <= low_d;
      drive_high <= high_d;
      drive_oe   <= low_d | high_d;
    end
  end
endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS      = 21,
  parameter int START_MIN      = 4,
  parameter int START_MAX      = 8,
  parameter int STOP_QUIET_LEN = 2,
  parameter int STOP_CONT_LEN  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] irq_in,
  input  logic                 line_in,
  output logic                 drive_low,
  output logic                 drive_high,
  output logic                 drive_oe,
  output logic                 quiet_mode
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int RUN_W  = $clog2(START_MAX + 2);

  agent_state_e         state_q, state_d;
  logic                 quiet_q, quiet_d;
  logic [NUM_SLOTS-1:0] report_q;
  logic [NUM_SLOTS-1:0] report_nxt;

  logic [RUN_W-1:0]  run_len;
  logic              rise;
  logic              start_ok;
  logic              load;
  logic              wake_req;
  logic              cur_active;
  logic [SLOT_W-1:0] cur_slot;
  slot_phase_e       cur_phase;
  logic              nxt_active;
  logic [SLOT_W-1:0] nxt_slot;
  slot_phase_e       nxt_phase;
  logic              frame_last;

  sirq_lowrun #(.RUN_W(RUN_W)) u_lowrun (
    .clk(clk), .rst(rst), .line_in(line_in),
    .run_len(run_len), .rise(rise)
  );

  assign start_ok = rise && (run_len >= RUN_W'(START_MIN)) && (run_len <= RUN_W'(START_MAX));
  assign load     = (state_q == ST_IDLE) && start_ok;

  // quiet-mode wake: one-clock low on an idle wire when the inputs moved
  assign wake_req = (state_q == ST_IDLE) && quiet_q && line_in && !rise &&
                    (irq_in != report_q) && !drive_low;

  assign report_nxt = load ? irq_in : report_q;

  sirq_slot_ctr #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctr (
    .clk(clk), .rst(rst), .load(load),
    .active_q(cur_active), .slot_q(cur_slot), .phase_q(cur_phase),
    .nxt_active(nxt_active), .nxt_slot(nxt_slot), .nxt_phase(nxt_phase),
    .last(frame_last)
  );

  sirq_slot_drv #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_drv (
    .clk(clk), .rst(rst),
    .nxt_active(nxt_active), .nxt_slot(nxt_slot), .nxt_phase(nxt_phase),
    .report_nxt(report_nxt), .wake_req(wake_req),
    .drive_low(drive_low), .drive_high(drive_high), .drive_oe(drive_oe)
  );

  always_comb begin
    state_d = state_q;
    quiet_d = quiet_q;
    case (state_q)
      ST_IDLE:   if (load) state_d = ST_FRAMES;
      ST_FRAMES: if (frame_last) state_d = ST_STOP;
      ST_STOP: begin
        if (rise) begin
          state_d = ST_IDLE;
          if (run_len == RUN_W'(STOP_QUIET_LEN))     quiet_d = 1'b1;
          else if (run_len == RUN_W'(STOP_CONT_LEN)) quiet_d = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      quiet_q  <= 1'b0;
      report_q <= '0;
    end else begin
      state_q  <= state_d;
      quiet_q  <= quiet_d;
      report_q <= report_nxt;
    end
  end

  assign quiet_mode = quiet_q;
endmodule

// File: rtl/sirq_agent_chk.sv
module sirq_agent_chk
  import sirq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       drive_low,
  input logic       drive_high,
  input logic       drive_oe,
  input logic       quiet_mode,
  input logic [1:0] state_q,
  input logic [1:0] phase_q,
  input logic       frame_active
);
  assert_high_after_low_R5: assert property (@(posedge clk) disable iff (rst)
    drive_high |-> $past(drive_low));

  assert_no_fight_R5: assert property (@(posedge clk) disable iff (rst)
    !(drive_low && drive_high));

  assert_oe_match_R6: assert property (@(posedge clk) disable iff (rst)
    drive_oe == (drive_low || drive_high));

  assert_turn_release_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_active && phase_q == PH_TURN) |-> !drive_oe);

  assert_stop_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP) |-> !drive_oe);

  assert_cont_no_wake_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !quiet_mode) |-> !drive_low);

  assert_single_low_R12: assert property (@(posedge clk) disable iff (rst)
    drive_low |=> !drive_low);
endmodule

bind sirq_agent sirq_agent_chk u_chk (
  .clk(clk), .rst(rst),
  .drive_low(drive_low), .drive_high(drive_high), .drive_oe(drive_oe),
  .quiet_mode(quiet_mode), .state_q(state_q), .phase_q(cur_phase),
  .frame_active(cur_active)
);

// File: tb/sirq_agent_test.sv
module sirq_agent_test;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] irq_in;
  logic         host_low;
  logic         line;
  logic         drive_low, drive_high, drive_oe, quiet_mode;

  int checks = 0;
  int errors = 0;
  bit exp_quiet;
  logic [N-1:0] rep;

  always #2 clk = ~clk;

  // open-drain wire: low if anyone pulls low, else high
  assign line = !(host_low || drive_low);

  sirq_agent #(.NUM_SLOTS(N)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .line_in(line),
    .drive_low(drive_low), .drive_high(drive_high), .drive_oe(drive_oe),
    .quiet_mode(quiet_mode)
  );

  task automatic check_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit stop_mode(int len, bit cur);
    if (len == 2) return 1'b1;
    if (len == 3) return 1'b0;
    return cur;
  endfunction

  // entry: negedge inside slot 0 sample period
  task automatic run_frames(logic [N-1:0] snap, bit scramble);
    for (int s = 0; s < N; s++) begin
      check_eq(s == 0 ? "R2" : (scramble ? "R7" : "R4"), "sample low", drive_low, snap[s]);
      check_eq("R6", "sample oe", drive_oe, snap[s]);
      check_eq("R5", "sample high", drive_high, 0);
      if (scramble) irq_in = N'($urandom);
      @(negedge clk);
      check_eq("R5", "recovery high", drive_high, snap[s]);
      check_eq("R4", "recovery low", drive_low, 0);
      @(negedge clk);
      check_eq("R6", "turnaround oe", drive_oe, 0);
      @(negedge clk);
    end
    irq_in = snap;
  endtask

  task automatic host_start(int len);
    host_low = 1'b1;
    repeat (len) @(negedge clk);
    host_low = 1'b0;
    @(negedge clk);
  endtask

  task automatic agent_start(logic [N-1:0] nv, int len);
    irq_in = nv;
    @(negedge clk);
    check_eq("R9", "wake pulse", drive_low, 1);
    host_low = 1'b1;
    @(negedge clk);
    check_eq("R9", "wake released", drive_low, 0);
    repeat (len - 1) @(negedge clk);
    host_low = 1'b0;
    @(negedge clk);
  endtask

  task automatic stop_frame(int len);
    host_low = 1'b1;
    repeat (len) begin
      @(negedge clk);
      check_eq("R8", "stop silent", drive_oe, 0);
    end
    host_low = 1'b0;
    @(negedge clk);
    exp_quiet = stop_mode(len, exp_quiet);
    check_eq("R8", "mode after stop", quiet_mode, exp_quiet);
  endtask

  task automatic round(logic [N-1:0] nv, int len, bit scramble, int stop_len);
    if (exp_quiet && nv != rep) agent_start(nv, len);
    else begin irq_in = nv; host_start(len); end
    rep = nv;
    run_frames(rep, scramble);
    stop_frame(stop_len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; host_low = 1'b0; irq_in = '0; exp_quiet = 1'b0; rep = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "oe after reset", drive_oe, 0);
    check_eq("R1", "low after reset", drive_low, 0);
    check_eq("R1", "high after reset", drive_high, 0);
    check_eq("R1", "mode after reset", quiet_mode, 0);

    // continuous mode: irq changes never cause a start
    irq_in = 5'b10110;
    repeat (6) begin @(negedge clk); check_eq("R10", "no wake continuous", drive_low, 0); end

    // start lengths just outside the window are ignored
    host_start(3);
    repeat (3 * N) begin check_eq("R3", "short start ignored", drive_oe, 0); @(negedge clk); end
    host_start(9);
    repeat (3 * N) begin check_eq("R3", "long start ignored", drive_oe, 0); @(negedge clk); end

    round(5'b10110, 4, 1'b0, 3);
    round(5'b01001, 8, 1'b1, 2);          // switch to quiet
    repeat (5) begin @(negedge clk); check_eq("R11", "quiet no change", drive_oe, 0); end
    round(5'b11111, 4, 1'b0, 5);          // agent wake at min length, mode kept
    round(5'b00001, 8, 1'b1, 3);          // agent wake at max length, back to continuous
    round(5'b00000, 6, 1'b0, 3);

    for (int i = 0; i < 24; i++) begin
      int sl;
      case ($urandom % 3)
        0: sl = 2;
        1: sl = 3;
        default: sl = 5;
      endcase
      round(N'($urandom), 4 + int'($urandom % 5), 1'($urandom), sl);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule